// File: doc/BRIEF.md
# Keyed-Hash Job Sequencer

This block runs one keyed-hash (HMAC) job at a time in front of an external SHA-256 compression core. Software drives it through a small register bus. A job starts with a start strobe and the choice of an output target and a key slot. A config-finish strobe then checks that the chosen slot's purpose tag allows that target. After the check the sequencer feeds the key, XOR-ed with the inner pad byte, to the core as the first block. It then accepts the caller's message blocks, one sixteen-word block at a time. Each block after the first is preceded by a command that says whether it is an ordinary block or the final, already padded, block. A one-block command and an end command close the message in the two other legal ways.

Once the inner digest is known, the outer pass runs without software help: the key XOR-ed with the outer pad byte, and then a block that carries the inner digest. The result is readable on the bus only for the user target. For the other targets it is held for the two internal consumers (a signature unit and a debug-port unlock), each with its own valid flag and its own invalidate strobe.

States: IDLE (no job), CFG (target and slot writable), HALT (purpose check failed, waiting for finish), KEY (inner key block in core), FIRST (waiting for first message block), MSG (message block in core), NEXT (waiting for continue/pad/one-block/end), READY (waiting for the next block), EPAD (automatic padding block in core), OKEY (outer key block in core), OMSG (outer digest block in core), DONE (result held). Transitions: IDLE-start→CFG; CFG-config-finish→KEY on match or →HALT on mismatch; KEY-ack→FIRST; FIRST/READY-block-written→MSG; MSG-ack→OKEY if the block was marked final, else →NEXT; NEXT-continue/pad→READY; NEXT-one-block→OKEY; NEXT-end→EPAD; EPAD-ack→OKEY; OKEY-ack→OMSG; OMSG-ack→DONE; any non-busy state-finish→IDLE; a wrong-state command →IDLE with error.

Top module: `hmac_cmd_seq`

## Requirements
- R1: A key slot index (write address 0x02, full 32-bit value) of 0 to 5 selects that slot. An index of 6 or more makes config-finish (address 0x03) set the error flag (read address 0x01, bit 0) and start no hashing.
- R2: Target codes written to address 0x01 (bits 1:0) are 0 user, 1 signature, 2 debug unlock and 3 both. They require the purpose tags 8, 7, 6 and 5 in that order. On a mismatch the error flag is set, and block-written strobes (address 0x06) are then ignored: busy stays 0 and no core request is made.
- R3: After a passing config-finish, the first core request carries the IV as its chain. Its block holds the key XOR 0x36363636 in words 0 to 7 (word i at bits 32i+31:32i) and 0x36363636 in words 8 to 15.
- R4: Message words are written to addresses 0x10 to 0x1F (word i at 0x10+i), and a block-written strobe sends them to the core chained on the previous digest. A continue command (0x04) precedes each later non-final block. A pad command (0x05) precedes the final block, after which the outer pass begins.
- R5: A one-block command (0x07) after exactly one message block closes the message and starts the outer pass.
- R6: An end command (0x08) makes the core absorb an added block with word 0 = 0x80000000, word 15 = (blocks+1)*512 and all other words zero.
- R7: The outer pass sends the key XOR 0x5c5c5c5c block (with 0x5c5c5c5c in words 8 to 15) chained on the IV. It then sends a block of the inner digest in words 0 to 7, 0x80000000 in word 8 and 768 in word 15. The digest that returns is the result.
- R8: Address 0x00 reads 1 while a core request is outstanding. While it is 1, every bus write except the invalidate strobes is ignored.
- R9: When the target is 0, the result words read at 0x20 to 0x27 after the job. Writing 2 to address 0x09 clears them to zero and returns to IDLE. Any other value written there is ignored, and a result that is not user-readable always reads as zero.
- R10: On completion, the signature valid flag is set for targets 1 and 3 and the debug valid flag for targets 2 and 3, with the digest on the downstream output. Strobes at 0x0A and 0x0B clear the signature and debug flags.
- R11: A command that arrives in a state where it is illegal sets the error flag and returns to IDLE. This includes a one-block command after more than one block and config-finish in IDLE. A start strobe (0x00) in IDLE clears the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Write address |
| reg_wdata | input | 32 | Write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| key_bits | input | 1536 | Six 256-bit stored keys, slot s at bits 256s+255:256s |
| key_tags | input | 24 | Six 4-bit purpose tags |
| core_req | output | 1 | Block request to the compression core |
| core_chain | output | 256 | Chain value for the request |
| core_block | output | 512 | Block for the request |
| core_ack | input | 1 | One-cycle completion from the core |
| core_digest | input | 256 | Digest returned with core_ack |
| sig_key_valid | output | 1 | Digest held for the signature unit |
| dbg_key_valid | output | 1 | Digest held for the debug unlock |
| down_digest | output | 256 | Held digest for the internal consumers |

## Verification
The assertions check on every cycle that the state, the block and the chain stay frozen while a core request waits, and that no request exists while the error flag is set. They also check that an out-of-range slot lands in HALT with the error raised, that an invalidate strobe always clears its flag, and that a result which is not user-readable reads as zero. Only the bench scenarios can show that the chained digests are correct, which means rebuilding every block the core receives. The same holds for the block order under the pad, one-block and end closings, for commands written during a busy window having no effect, and for the error and abort paths.

// File: rtl/hseq_pkg.sv
package hseq_pkg;
    localparam int WORD_W = 32;
    localparam int KEY_W  = 256;
    localparam int BLK_W  = 512;

    typedef enum logic [3:0] {
        S_IDLE, S_CFG, S_HALT, S_KEY, S_FIRST, S_MSG,
        S_NEXT, S_READY, S_EPAD, S_OKEY, S_OMSG, S_DONE
    } state_t;

    localparam logic [KEY_W-1:0] SHA_IV = {
        32'h5be0cd19, 32'h1f83d9ab, 32'h9b05688c, 32'h510e527f,
        32'ha54ff53a, 32'h3c6ef372, 32'hbb67ae85, 32'h6a09e667};

    localparam logic [WORD_W-1:0] IPAD_W = 32'h36363636;
    localparam logic [WORD_W-1:0] OPAD_W = 32'h5c5c5c5c;

    localparam logic [5:0] A_START   = 6'h00;
    localparam logic [5:0] A_TARGET  = 6'h01;
    localparam logic [5:0] A_SLOT    = 6'h02;
    localparam logic [5:0] A_CFGDONE = 6'h03;
    localparam logic [5:0] A_CONT    = 6'h04;
    localparam logic [5:0] A_PAD     = 6'h05;
    localparam logic [5:0] A_BLK     = 6'h06;
    localparam logic [5:0] A_ONE     = 6'h07;
    localparam logic [5:0] A_END     = 6'h08;
    localparam logic [5:0] A_FIN     = 6'h09;
    localparam logic [5:0] A_INV_SIG = 6'h0A;
    localparam logic [5:0] A_INV_DBG = 6'h0B;

    function automatic logic [3:0] tag_for(input logic [1:0] target);
        case (target)
            2'd0:    return 4'd8;
            2'd1:    return 4'd7;
            2'd2:    return 4'd6;
            default: return 4'd5;
        endcase
    endfunction
endpackage

// File: rtl/hseq_key_select.sv
module hseq_key_select
    import hseq_pkg::*;
#(
    parameter int NSLOT = 6,
    parameter int TAG_W = 4
) (
    input  logic [NSLOT*KEY_W-1:0] key_bits,
    input  logic [NSLOT*TAG_W-1:0] key_tags,
    input  logic [31:0]            slot,
    input  logic [1:0]             target,
    output logic [KEY_W-1:0]       key,
    output logic                   purpose_ok
);
    logic [TAG_W-1:0] tag;
    logic             in_range;

    always_comb begin
        key      = '0;
        tag      = '0;
        in_range = (slot < 32'(NSLOT));
        for (int s = 0; s < NSLOT; s++) begin
            if (slot == 32'(s)) begin
                key = key_bits[s*KEY_W +: KEY_W];
                tag = key_tags[s*TAG_W +: TAG_W];
            end
        end
        purpose_ok = in_range && (tag == TAG_W'(tag_for(target)));
    end
endmodule

// File: rtl/hseq_block_build.sv
module hseq_block_build
    import hseq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  state_t             state,
    input  logic [KEY_W-1:0]   key,
    input  logic [KEY_W-1:0]   chain_q,
    input  logic [KEY_W-1:0]   inner_q,
    input  logic [BLK_W-1:0]   msg_q,
    input  logic [CNT_W-1:0]   nblk,
    output logic [BLK_W-1:0]   blk,
    output logic [KEY_W-1:0]   chain
);
    localparam int NW = KEY_W / WORD_W;

    logic [KEY_W-1:0] ikey, okey;
    logic [31:0]      end_len;

    for (genvar g = 0; g < NW; g++) begin : g_pad
        assign ikey[g*WORD_W +: WORD_W] = key[g*WORD_W +: WORD_W] ^ IPAD_W;
        assign okey[g*WORD_W +: WORD_W] = key[g*WORD_W +: WORD_W] ^ OPAD_W;
    end

    assign end_len = (32'(nblk) + 32'd1) << 9;

    always_comb begin
        blk   = '0;
        chain = chain_q;
        unique case (state)
            S_KEY:  begin blk = {{NW{IPAD_W}}, ikey}; chain = SHA_IV; end
            S_MSG:  blk = msg_q;
            S_EPAD: blk = {end_len, 448'b0, 32'h80000000};
            S_OKEY: begin blk = {{NW{OPAD_W}}, okey}; chain = SHA_IV; end
            S_OMSG: blk = {32'd768, 192'b0, 32'h80000000, inner_q};
            default: chain = SHA_IV;
        endcase
    end
endmodule

// File: rtl/hmac_cmd_seq.sv
module hmac_cmd_seq
    import hseq_pkg::*;
#(
    parameter int NSLOT = 6,
    parameter int TAG_W = 4,
    parameter int CNT_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [5:0]             reg_addr,
    input  logic [31:0]            reg_wdata,
    input  logic [5:0]             rd_addr,
    output logic [31:0]            rd_data,
    input  logic [NSLOT*256-1:0]   key_bits,
    input  logic [NSLOT*TAG_W-1:0] key_tags,
    output logic                   core_req,
    output logic [255:0]           core_chain,
    output logic [511:0]           core_block,
    input  logic                   core_ack,
    input  logic [255:0]           core_digest,
    output logic                   sig_key_valid,
    output logic                   dbg_key_valid,
    output logic [255:0]           down_digest
);
    state_t             state_q, state_d;
    logic               err_q, err_set, err_clr;
    logic [1:0]         target_q;
    logic [31:0]        slot_q;
    logic [BLK_W-1:0]   msg_q;
    logic [KEY_W-1:0]   h_q, inner_q, res_q, key;
    logic [CNT_W-1:0]   nblk_q;
    logic               pad_q, final_q, user_v, sig_v, dbg_v;
    logic               busy, accept, purpose_ok;
    logic               c_start, c_cfg, c_cont, c_pad, c_blk, c_one, c_end, c_fin, c_cmd;

    assign busy    = state_q inside {S_KEY, S_MSG, S_EPAD, S_OKEY, S_OMSG};
    assign accept  = reg_wr && !busy;
    assign c_start = accept && reg_addr == A_START;
    assign c_cfg   = accept && reg_addr == A_CFGDONE;
    assign c_cont  = accept && reg_addr == A_CONT;
    assign c_pad   = accept && reg_addr == A_PAD;
    assign c_blk   = accept && reg_addr == A_BLK;
    assign c_one   = accept && reg_addr == A_ONE;
    assign c_end   = accept && reg_addr == A_END;
    assign c_fin   = accept && reg_addr == A_FIN && reg_wdata == 32'd2;
    assign c_cmd   = c_cfg || c_cont || c_pad || c_blk || c_one || c_end;

    hseq_key_select #(.NSLOT(NSLOT), .TAG_W(TAG_W)) key_sel_i (
        .key_bits(key_bits), .key_tags(key_tags), .slot(slot_q),
        .target(target_q), .key(key), .purpose_ok(purpose_ok));

    hseq_block_build #(.CNT_W(CNT_W)) blk_i (
        .state(state_q), .key(key), .chain_q(h_q), .inner_q(inner_q),
        .msg_q(msg_q), .nblk(nblk_q), .blk(core_block), .chain(core_chain));

    // next-state logic
    always_comb begin
        state_d = state_q;
        err_set = 1'b0;
        err_clr = 1'b0;
        if (!busy) begin
            if (c_fin) state_d = S_IDLE;
            else unique case (state_q)
                S_IDLE: begin
                    if (c_start) begin state_d = S_CFG; err_clr = 1'b1; end
                    else if (c_cmd) err_set = 1'b1;
                end
                S_CFG: begin
                    if (c_cfg) begin
                        if (purpose_ok) state_d = S_KEY;
                        else begin state_d = S_HALT; err_set = 1'b1; end
                    end else if (c_cmd || c_start) begin
                        state_d = S_IDLE; err_set = 1'b1;
                    end
                end
                S_FIRST, S_READY: begin
                    if (c_blk) state_d = S_MSG;
                    else if (c_cmd || c_start) begin state_d = S_IDLE; err_set = 1'b1; end
                end
                S_NEXT: begin
                    if (c_cont || c_pad) state_d = S_READY;
                    else if (c_one && nblk_q == CNT_W'(1)) state_d = S_OKEY;
                    else if (c_end) state_d = S_EPAD;
                    else if (c_cmd || c_start) begin state_d = S_IDLE; err_set = 1'b1; end
                end
                S_DONE: begin
                    if (c_cmd || c_start) begin state_d = S_IDLE; err_set = 1'b1; end
                end
                default: ;
            endcase
        end else if (core_ack) begin
            unique case (state_q)
                S_KEY:   state_d = S_FIRST;
                S_MSG:   state_d = final_q ? S_OKEY : S_NEXT;
                S_EPAD:  state_d = S_OKEY;
                S_OKEY:  state_d = S_OMSG;
                S_OMSG:  state_d = S_DONE;
                default: ;
            endcase
        end
    end

    // state and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            err_q    <= 1'b0;
            target_q <= '0;
            slot_q   <= '0;
            msg_q    <= '0;
            h_q      <= '0;
            inner_q  <= '0;
            res_q    <= '0;
            nblk_q   <= '0;
            pad_q    <= 1'b0;
            final_q  <= 1'b0;
            user_v   <= 1'b0;
            sig_v    <= 1'b0;
            dbg_v    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (err_clr) err_q <= 1'b0;
            else if (err_set) err_q <= 1'b1;
            if (accept && state_q == S_CFG && reg_addr == A_TARGET) target_q <= reg_wdata[1:0];
            if (accept && state_q == S_CFG && reg_addr == A_SLOT) slot_q <= reg_wdata;
            if (accept && reg_addr[5:4] == 2'b01) msg_q[{reg_addr[3:0], 5'b0} +: 32] <= reg_wdata;
            if (state_q == S_IDLE && state_d == S_CFG) nblk_q <= '0;
            if (!busy && state_d == S_MSG) begin
                nblk_q  <= nblk_q + 1'b1;
                final_q <= (state_q == S_READY) && pad_q;
            end
            if (state_q == S_NEXT && state_d == S_READY) pad_q <= c_pad;
            if (state_q == S_NEXT && state_d == S_OKEY) inner_q <= h_q;
            if (busy && core_ack) begin
                if (state_q != S_OMSG) h_q <= core_digest;
                if (state_q == S_EPAD || (state_q == S_MSG && final_q)) inner_q <= core_digest;
                if (state_q == S_OMSG) begin
                    res_q  <= core_digest;
                    user_v <= (target_q == 2'd0);
                    sig_v  <= (target_q == 2'd1) || (target_q == 2'd3);
                    dbg_v  <= (target_q == 2'd2) || (target_q == 2'd3);
                end
            end
            if (!busy && state_d == S_IDLE) user_v <= 1'b0;
            if (reg_wr && reg_addr == A_INV_SIG) sig_v <= 1'b0;
            if (reg_wr && reg_addr == A_INV_DBG) dbg_v <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        core_req      = busy;
        sig_key_valid = sig_v;
        dbg_key_valid = dbg_v;
        down_digest   = (sig_v || dbg_v) ? res_q : '0;
        rd_data       = '0;
        if (rd_addr == A_START) rd_data = {31'b0, busy};
        else if (rd_addr == A_TARGET) rd_data = {31'b0, err_q};
        else if (rd_addr[5:3] == 3'b100 && user_v) rd_data = res_q[{rd_addr[2:0], 5'b0} +: 32];
    end

    AST_BAD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CFG && c_cfg && slot_q >= 32'(NSLOT)) |=> (err_q && state_q == S_HALT)); // R1
    AST_ERR_NO_HASH: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> !core_req); // R2
    AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && !core_ack) |=> (core_req && $stable(state_q))); // R8
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && !core_ack) |=> ($stable(core_block) && $stable(core_chain))); // R3
    AST_RESULT_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr[5:3] == 3'b100 && !user_v) |-> rd_data == 32'd0); // R9
    AST_INV_SIG: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_INV_SIG) |=> !sig_key_valid); // R10
    AST_INV_DBG: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_INV_DBG) |=> !dbg_key_valid); // R10
endmodule

// File: tb/hmac_cmd_seq_tb_top.sv
module hmac_cmd_seq_tb_top;
    localparam logic [255:0] IV = {
        32'h5be0cd19, 32'h1f83d9ab, 32'h9b05688c, 32'h510e527f,
        32'ha54ff53a, 32'h3c6ef372, 32'hbb67ae85, 32'h6a09e667};
    localparam int M_PAD = 0, M_ONE = 1, M_END = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [5:0] reg_addr = '0, rd_addr = '0;
    logic [31:0] reg_wdata = '0, rd_data;
    logic [1535:0] key_bits;
    logic [23:0] key_tags;
    logic core_req, core_ack, sig_key_valid, dbg_key_valid;
    logic [255:0] core_chain, core_digest, down_digest;
    logic [511:0] core_block;

    logic [255:0] keys [6];
    logic [3:0]   tags [6];
    logic [511:0] msgs [4];
    logic [511:0] blk_log [16];
    logic [255:0] chain_log [16];
    int log_n = 0;
    int lat = 1;
    int checks = 0, fails = 0;
    logic [255:0] exp_res, exp_inner;

    always #10 clk = ~clk;

    always_comb begin
        for (int s = 0; s < 6; s++) begin
            key_bits[s*256 +: 256] = keys[s];
            key_tags[s*4 +: 4] = tags[s];
        end
    end

    hmac_cmd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .key_bits(key_bits), .key_tags(key_tags), .core_req(core_req),
        .core_chain(core_chain), .core_block(core_block), .core_ack(core_ack),
        .core_digest(core_digest), .sig_key_valid(sig_key_valid),
        .dbg_key_valid(dbg_key_valid), .down_digest(down_digest));

    function automatic logic [255:0] model(input logic [255:0] c, input logic [511:0] b);
        logic [255:0] d;
        for (int i = 0; i < 8; i++) begin
            logic [31:0] w = c[i*32 +: 32];
            d[i*32 +: 32] = {w[30:0], w[31]} ^ b[i*32 +: 32] ^ b[(i+8)*32 +: 32]
                            ^ (32'h9e3779b9 * 32'(i + 1));
        end
        return d;
    endfunction

    function automatic logic [511:0] padblk(input logic [255:0] k, input logic [31:0] w);
        return {{8{w}}, k ^ {8{w}}};
    endfunction

    function automatic logic [511:0] outer_blk(input logic [255:0] inner);
        return {32'd768, 192'b0, 32'h80000000, inner};
    endfunction

    function automatic logic [511:0] endpad(input int n);
        return {32'((n + 1) * 512), 448'b0, 32'h80000000};
    endfunction

    function automatic logic [1:0] tgt_of(input logic [3:0] t);
        return 2'(4'd8 - t);
    endfunction

    task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        int n = 0;
        rd(6'h00, v);
        while (v != 0 && n < 3000) begin
            @(negedge clk);
            rd(6'h00, v);
            n++;
        end
    endtask

    task automatic read_result(output logic [255:0] r);
        logic [31:0] v;
        for (int w = 0; w < 8; w++) begin
            rd(6'h20 + 6'(w), v);
            r[w*32 +: 32] = v;
        end
    endtask

    task automatic write_block(input int b);
        for (int w = 0; w < 16; w++) wr(6'h10 + 6'(w), msgs[b][w*32 +: 32]);
        wr(6'h06, 32'd1);
        wait_idle();
    endtask

    task automatic compute_exp(input int slot, input int nb, input int mode);
        logic [255:0] h;
        h = model(IV, padblk(keys[slot], 32'h36363636));
        for (int b = 0; b < nb; b++) h = model(h, msgs[b]);
        if (mode == M_END) h = model(h, endpad(nb));
        exp_inner = h;
        h = model(IV, padblk(keys[slot], 32'h5c5c5c5c));
        exp_res = model(h, outer_blk(exp_inner));
    endtask

    task automatic run_job(input int tgt, input int slot, input int nb, input int mode, input bit poke);
        logic [31:0] v;
        log_n = 0;
        wr(6'h00, 32'd1);
        wr(6'h01, 32'(tgt));
        wr(6'h02, 32'(slot));
        wr(6'h03, 32'd1);
        if (poke) begin
            rd(6'h00, v);
            chk("R8 busy reads 1 during key block", 512'(v), 512'd1);
            wr(6'h05, 32'd1);
        end
        wait_idle();
        if (poke) begin
            rd(6'h01, v);
            chk("R8 pad written while busy is ignored", 512'(v), 512'd0);
        end
        for (int b = 0; b < nb; b++) begin
            if (b > 0) wr((mode == M_PAD && b == nb - 1) ? 6'h05 : 6'h04, 32'd1);
            write_block(b);
        end
        if (mode == M_ONE) wr(6'h07, 32'd1);
        if (mode == M_END) wr(6'h08, 32'd1);
        wait_idle();
        compute_exp(slot, nb, mode);
        chk("R3 first block is key^ipad", blk_log[0], padblk(keys[slot], 32'h36363636));
        chk("R3 first chain is IV", 512'(chain_log[0]), 512'(IV));
        chk("R7 outer key block", blk_log[log_n-2], padblk(keys[slot], 32'h5c5c5c5c));
        chk("R7 outer digest block", blk_log[log_n-1], outer_blk(exp_inner));
        if (mode == M_END) chk("R6 automatic padding block", blk_log[1+nb], endpad(nb));
        rd(6'h01, v);
        chk("R11 no error on legal job", 512'(v), 512'd0);
    endtask

    task automatic check_user_result(input string req);
        logic [255:0] r;
        read_result(r);
        chk(req, 512'(r), 512'(exp_res));
    endtask

    // compression core model
    initial begin
        core_ack = 1'b0;
        core_digest = '0;
        forever begin
            @(negedge clk);
            if (rst_n && core_req) begin
                if (log_n < 16) begin
                    blk_log[log_n] = core_block;
                    chain_log[log_n] = core_chain;
                end
                log_n++;
                repeat (lat) @(negedge clk);
                core_digest = model(core_chain, core_block);
                core_ack = 1'b1;
                @(negedge clk);
                core_ack = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R8 actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [255:0] r;
        void'($urandom(32'd20210802));
        for (int s = 0; s < 6; s++)
            for (int w = 0; w < 8; w++) keys[s][w*32 +: 32] = $urandom;
        tags[0] = 4'd8; tags[1] = 4'd7; tags[2] = 4'd6;
        tags[3] = 4'd5; tags[4] = 4'd8; tags[5] = 4'd7;
        for (int b = 0; b < 4; b++)
            for (int w = 0; w < 16; w++) msgs[b][w*32 +: 32] = $urandom;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(6'h00, v); chk("R8 busy 0 after reset", 512'(v), 512'd0);
        rd(6'h01, v); chk("R11 error 0 after reset", 512'(v), 512'd0);
        read_result(r); chk("R9 result 0 after reset", 512'(r), 512'd0);
        chk("R10 valids 0 after reset", 512'({sig_key_valid, dbg_key_valid}), 512'd0);

        // wrong-state command
        wr(6'h03, 32'd1);
        rd(6'h01, v); chk("R11 config-finish in IDLE sets error", 512'(v), 512'd1);
        wr(6'h00, 32'd1);
        rd(6'h01, v); chk("R11 start clears error", 512'(v), 512'd0);
        wr(6'h09, 32'd2);

        // slot out of range
        log_n = 0;
        wr(6'h00, 32'd1); wr(6'h01, 32'd0); wr(6'h02, 32'd6); wr(6'h03, 32'd1);
        rd(6'h01, v); chk("R1 slot 6 rejected", 512'(v), 512'd1);
        for (int w = 0; w < 16; w++) wr(6'h10 + 6'(w), 32'(w));
        wr(6'h06, 32'd1);
        rd(6'h00, v); chk("R2 block ignored after error (busy)", 512'(v), 512'd0);
        chk("R2 no core request after error", 512'(log_n), 512'd0);
        wr(6'h09, 32'd2);

        // purpose mismatch
        wr(6'h00, 32'd1); wr(6'h01, 32'd0); wr(6'h02, 32'd1); wr(6'h03, 32'd1);
        rd(6'h01, v); chk("R2 tag 7 rejected for user target", 512'(v), 512'd1);
        wr(6'h09, 32'd2);

        // three-block job with pad closing
        lat = 2;
        run_job(0, 0, 3, M_PAD, 1'b0);
        check_user_result("R4 three-block result");
        wr(6'h09, 32'd1);
        check_user_result("R9 finish value 1 ignored");
        wr(6'h09, 32'd2);
        read_result(r); chk("R9 finish value 2 clears result", 512'(r), 512'd0);

        // single block
        run_job(0, 4, 1, M_ONE, 1'b0);
        check_user_result("R5 single-block result");
        wr(6'h09, 32'd2);

        // end closing
        lat = 0;
        run_job(0, 0, 2, M_END, 1'b0);
        check_user_result("R6 end-closed result");
        wr(6'h09, 32'd2);

        // command during busy
        lat = 6;
        run_job(0, 0, 2, M_PAD, 1'b1);
        check_user_result("R8 result after ignored command");
        wr(6'h09, 32'd2);
        lat = 1;

        // one-block after two blocks is illegal
        wr(6'h00, 32'd1); wr(6'h01, 32'd0); wr(6'h02, 32'd0); wr(6'h03, 32'd1);
        wait_idle();
        write_block(0);
        wr(6'h04, 32'd1);
        write_block(1);
        wr(6'h07, 32'd1);
        rd(6'h01, v); chk("R11 one-block after two blocks sets error", 512'(v), 512'd1);
        rd(6'h00, v); chk("R11 aborted to idle", 512'(v), 512'd0);

        // signature target
        run_job(1, 1, 2, M_PAD, 1'b0);
        chk("R10 signature valid only", 512'({sig_key_valid, dbg_key_valid}), 512'b10);
        chk("R10 downstream digest", 512'(down_digest), 512'(exp_res));
        read_result(r); chk("R9 result hidden for signature target", 512'(r), 512'd0);
        wr(6'h09, 32'd2);
        wr(6'h0A, 32'd1);
        chk("R10 signature invalidated", 512'(sig_key_valid), 512'd0);

        // both targets
        run_job(3, 3, 1, M_END, 1'b0);
        chk("R10 both valid", 512'({sig_key_valid, dbg_key_valid}), 512'b11);
        wr(6'h0B, 32'd1);
        chk("R10 debug invalidated, signature kept", 512'({sig_key_valid, dbg_key_valid}), 512'b10);
        wr(6'h09, 32'd2);
        wr(6'h0A, 32'd1);

        // random jobs
        for (int j = 0; j < 16; j++) begin
            int mode, nb, slot;
            logic [1:0] t;
            mode = int'($urandom % 3);
            nb = (mode == M_ONE) ? 1 : (mode == M_PAD ? 2 + int'($urandom % 3) : 1 + int'($urandom % 3));
            slot = int'($urandom % 6);
            t = tgt_of(tags[slot]);
            lat = int'($urandom % 4);
            for (int b = 0; b < 4; b++)
                for (int w = 0; w < 16; w++) msgs[b][w*32 +: 32] = $urandom;
            run_job(int'(t), slot, nb, mode, 1'b0);
            if (t == 2'd0) check_user_result("R4 random job result");
            else begin
                chk("R10 random downstream digest", 512'(down_digest), 512'(exp_res));
                read_result(r); chk("R9 random hidden result", 512'(r), 512'd0);
            end
            wr(6'h09, 32'd2);
            wr(6'h0A, 32'd1);
            wr(6'h0B, 32'd1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule